// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This block measures how far apart two blocks of byte data are. Typical data is a pair of 16x16 pixel tiles taken from consecutive video frames, with each tile stored as a 256-entry byte array. A one-cycle start request launches a run. A small controller then steps one index through both arrays. For each entry it fetches the pair of bytes from two external memories, forms the magnitude of their difference, and adds that magnitude into a 32-bit accumulator. When every entry has been visited, the total is copied into an output register that stays visible until the next run ends.

The two arrays are outside the block. The engine drives one address bus that both memories share, plus a read strobe. The memories return their bytes on two separate data buses in the same cycle, as purely combinational read data. Each entry takes two cycles: a bound test, then an accumulate step. A full run therefore occupies a fixed number of cycles, and a one-cycle completion pulse marks its end.

Top module: `sad_engine`

## Requirements
- R1: While the synchronous reset is high and in the cycle after it, `sad_out` is 0 and both `done` and `rd_en` are 0.
- R2: In the idle state, with no start request, `rd_en` and `done` stay 0. A start that is high at a clock edge in the idle state begins a run.
- R3: Each run asserts `rd_en` in exactly 256 cycles. The addresses in those cycles are 0, 1, ..., 255 in that order, and `addr` is the low 8 bits of the 9-bit index. No two consecutive cycles both have `rd_en` high.
- R4: At the end of a run, the result equals the sum over all 256 entries of |A[k] - B[k]|. The bytes are unsigned 0..255, and the result is correct whichever operand is larger: 256 entries of 255 versus 0 give 65280 in both orders.
- R5: `done` is high for exactly one cycle. That cycle is the 515th cycle of the run, counting the cycle right after the edge that accepted start as the first.
- R6: During a run, including the `done` cycle, `sad_out` keeps the previous result. It changes to the new total at the clock edge that ends the `done` cycle.
- R7: A start request during a run is ignored. The result and the timing of `done` are the same as without it.
- R8: A synchronous reset in the middle of a run returns the engine to idle, clears `sad_out` to 0 and stops reads. A later start then gives a correct run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run, sampled in idle |
| addr | output | 8 | Shared entry address to both memories |
| rd_en | output | 1 | Read strobe, high while an entry is being accumulated |
| a_rdata | input | 8 | Byte of the first array at `addr` |
| b_rdata | input | 8 | Byte of the second array at `addr` |
| sad_out | output | 32 | Result register holding the last completed total |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle by assertions in the RTL. The result register stays stable except when the controller loads it. The completion pulse and the read strobe never last two cycles in a row. A read never happens with the index out of range. The accumulator never decreases while it is being loaded. Reset clears the outputs. Only the bench scenarios can show the rest: the exact totals for equal, extreme and mixed data, the address order, the 515-cycle run length, that a stray start has no effect, and recovery from a reset in mid-run.

// File: rtl/sad_pkg.sv
package sad_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CLR  = 3'd1,
      ST_TEST = 3'd2,
      ST_ACC  = 3'd3,
      ST_OUT  = 3'd4
   } sad_state_e;

   // Datapath control bundle driven by the controller
   typedef struct packed {
      logic idx_clr;
      logic idx_inc;
      logic acc_clr;
      logic acc_ld;
      logic res_ld;
      logic rd;
   } sad_ctl_t;

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
   parameter int DATA_W         = 8,
   parameter bit SIGNED_EXTEND  = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] mag
);

   generate
      if (SIGNED_EXTEND) begin : g_wide_sub
         // One subtractor one bit wider, then conditional negate
         logic signed [DATA_W:0] ext_a;
         logic signed [DATA_W:0] ext_b;
         logic signed [DATA_W:0] delta;
         always_comb begin
            ext_a = $signed({1'b0, op_a});
            ext_b = $signed({1'b0, op_b});
            delta = ext_a - ext_b;
            mag   = delta[DATA_W] ? DATA_W'(-delta) : DATA_W'(delta);
         end
      end else begin : g_cmp_sub
         // Comparator selects the order of the subtraction
         always_comb begin
            mag = (op_a >= op_b) ? (op_a - op_b) : (op_b - op_a);
         end
      end
   endgenerate

endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
   import sad_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     start,
   input  logic     idx_lt,
   output sad_ctl_t ctl,
   output logic     done
);

   sad_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start) state_d = ST_CLR;
         ST_CLR:  state_d = ST_TEST;
         ST_TEST: state_d = idx_lt ? ST_ACC : ST_OUT;
         ST_ACC:  state_d = ST_TEST;
         ST_OUT:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      ctl = '0;
      case (state_q)
         ST_CLR: begin
            ctl.idx_clr = 1'b1;
            ctl.acc_clr = 1'b1;
         end
         ST_ACC: begin
            ctl.acc_ld  = 1'b1;
            ctl.idx_inc = 1'b1;
            ctl.rd      = 1'b1;
         end
         ST_OUT: ctl.res_ld = 1'b1;
         default: ctl = '0;
      endcase
   end

   assign done = (state_q == ST_OUT);

   // R5: completion pulse lasts one cycle
   a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R3: reads are separated by a bound test cycle
   a_r3_rd_spaced: assert property (@(posedge clk) disable iff (rst)
      ctl.rd |=> !ctl.rd);

   // R7: once running, the machine reaches idle only through the output state
   a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ACC) |=> (state_q == ST_TEST));

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
   import sad_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 256,
   parameter int ACC_W         = 32,
   parameter bit SIGNED_EXTEND = 1'b1,
   localparam int ADDR_W       = $clog2(DEPTH),
   localparam int IDX_W        = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  sad_ctl_t          ctl,
   input  logic [DATA_W-1:0] a_rdata,
   input  logic [DATA_W-1:0] b_rdata,
   output logic              idx_lt,
   output logic [ADDR_W-1:0] addr,
   output logic [ACC_W-1:0]  sad_out
);

   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   logic [IDX_W-1:0]  idx_q;
   logic [ACC_W-1:0]  acc_q;
   logic [DATA_W-1:0] mag;

   sad_absdiff #(
      .DATA_W        (DATA_W),
      .SIGNED_EXTEND (SIGNED_EXTEND)
   ) u_absdiff (
      .op_a (a_rdata),
      .op_b (b_rdata),
      .mag  (mag)
   );

   always_ff @(posedge clk) begin
      if (rst || ctl.idx_clr) idx_q <= '0;
      else if (ctl.idx_inc)   idx_q <= idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || ctl.acc_clr) acc_q <= '0;
      else if (ctl.acc_ld)    acc_q <= acc_q + ACC_W'(mag);
   end

   always_ff @(posedge clk) begin
      if (rst)             sad_out <= '0;
      else if (ctl.res_ld) sad_out <= acc_q;
   end

   assign idx_lt = (idx_q < LIMIT);
   assign addr   = idx_q[ADDR_W-1:0];

   // R3: no read is issued with the index past the last entry
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
      ctl.rd |-> idx_lt);

   // R4: accumulation never wraps
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
      ctl.acc_ld |=> (acc_q >= $past(acc_q)));

   // R6: result register changes only on a load
   a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
      !ctl.res_ld |=> $stable(sad_out));

endmodule

// File: rtl/sad_engine.sv
module sad_engine
   import sad_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 256,
   parameter int ACC_W         = 32,
   parameter bit SIGNED_EXTEND = 1'b1,
   localparam int ADDR_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [ADDR_W-1:0] addr,
   output logic              rd_en,
   input  logic [DATA_W-1:0] a_rdata,
   input  logic [DATA_W-1:0] b_rdata,
   output logic [ACC_W-1:0]  sad_out,
   output logic              done
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sad_engine: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sad_engine: DEPTH must be at least 2");
      end
      if (ACC_W < DATA_W + ADDR_W) begin : g_bad_acc_w
         $error("sad_engine: ACC_W too narrow for the worst-case total");
      end
   endgenerate

   sad_ctl_t ctl;
   logic     idx_lt;

   sad_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .idx_lt (idx_lt),
      .ctl    (ctl),
      .done   (done)
   );

   sad_datapath #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .ACC_W         (ACC_W),
      .SIGNED_EXTEND (SIGNED_EXTEND)
   ) u_dp (
      .clk     (clk),
      .rst     (rst),
      .ctl     (ctl),
      .a_rdata (a_rdata),
      .b_rdata (b_rdata),
      .idx_lt  (idx_lt),
      .addr    (addr),
      .sad_out (sad_out)
   );

   assign rd_en = ctl.rd;

   // R1: reset leaves outputs cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (sad_out == '0 && !done && !rd_en));

   // R2: reads and completion never coincide
   a_r2_rd_done_excl: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && done));

endmodule

// File: tb/tb_sad_engine.sv
`timescale 1ns/1ps
module tb_sad_engine;

   localparam int N = 256;
   localparam int RUN_LAST = 514;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  addr;
   logic        rd_en;
   logic [7:0]  a_rdata;
   logic [7:0]  b_rdata;
   logic [31:0] sad_out;
   logic        done;

   logic [7:0] mem_a [N];
   logic [7:0] mem_b [N];

   assign a_rdata = mem_a[addr];
   assign b_rdata = mem_b[addr];

   sad_engine dut (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .addr    (addr),
      .rd_en   (rd_en),
      .a_rdata (a_rdata),
      .b_rdata (b_rdata),
      .sad_out (sad_out),
      .done    (done)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int val;
      int t0;
   } exp_t;
   exp_t q[$];
   exp_t e_pop;

   int rd_next = 0;
   int last_val = 0;
   bit pend = 1'b0;
   int pend_val = 0;
   int unsigned seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[23:16];
   endfunction

   // Monitor: pops expected results as the design completes runs
   always @(negedge clk) begin
      if (rst) begin
         pend = 1'b0;
      end else begin
         if (pend) begin
            chk(sad_out == 32'(pend_val), "R4", "total after done", sad_out, pend_val);
            chk(!done, "R5", "done width", done, 0);
            pend = 1'b0;
         end
         if (rd_en) begin
            chk(addr == 8'(rd_next), "R3", "read address", addr, rd_next);
            rd_next++;
         end
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R5", "unexpected done", 1, 0);
            end else begin
               e_pop = q.pop_front();
               chk(cyc == e_pop.t0 + RUN_LAST, "R5", "done cycle",
                   cyc - e_pop.t0 + 1, RUN_LAST + 1);
               chk(rd_next == N, "R3", "reads per run", rd_next, N);
               chk(sad_out == 32'(last_val), "R6", "old result in done cycle",
                   sad_out, last_val);
               pend = 1'b1;
               pend_val = e_pop.val;
               last_val = e_pop.val;
            end
            rd_next = 0;
         end
      end
   end

   task automatic fill(input int kind, output int total);
      total = 0;
      for (int k = 0; k < N; k++) begin
         case (kind)
            0: begin mem_a[k] = rnd(); mem_b[k] = mem_a[k]; end
            1: begin mem_a[k] = 8'd255; mem_b[k] = 8'd0; end
            2: begin mem_a[k] = 8'd0; mem_b[k] = 8'd255; end
            3: begin mem_a[k] = 8'(k); mem_b[k] = 8'(255 - k); end
            default: begin mem_a[k] = rnd(); mem_b[k] = rnd(); end
         endcase
         if (mem_a[k] >= mem_b[k]) total += int'(mem_a[k]) - int'(mem_b[k]);
         else                      total += int'(mem_b[k]) - int'(mem_a[k]);
      end
   endtask

   task automatic launch(input int total);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      q.push_back('{total, cyc});
   endtask

   task automatic run(input int kind, input bit extra_go);
      int total;
      fill(kind, total);
      launch(total);
      repeat (40) @(negedge clk);
      chk(sad_out == 32'(last_val), "R6", "hold during run", sad_out, last_val);
      if (extra_go) begin
         // R7: stray start mid-run
         repeat (60) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (pend || q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int total;
      repeat (3) @(negedge clk);
      chk(sad_out == 0, "R1", "sad_out in reset", sad_out, 0);
      chk(!done, "R1", "done in reset", done, 0);
      chk(!rd_en, "R1", "rd_en in reset", rd_en, 0);
      rst = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(!rd_en && !done, "R2", "idle quiet", {rd_en, done}, 0);
      end

      run(1, 1'b0);   // R4: 65280, A larger
      run(2, 1'b0);   // R4: 65280, B larger
      run(0, 1'b0);   // R4: equal arrays give 0
      run(3, 1'b0);   // R4: mixed ramp
      run(4, 1'b1);   // R7: random data with stray start

      // R8: reset in the middle of a run
      fill(4, total);
      launch(total);
      repeat (200) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      q.delete();
      rd_next = 0;
      last_val = 0;
      chk(sad_out == 0, "R8", "sad_out after mid-run reset", sad_out, 0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(!rd_en && !done, "R8", "quiet after reset", {rd_en, done}, 0);
      end
      run(1, 1'b0);   // R8: clean run after reset
      run(4, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule